// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel words. A one-cycle enable pulse arrives at sixteen times the bit rate, and the receiver watches the line only on those pulses. A falling edge marks a possible start bit. The receiver checks the centre of that start bit and then samples the data bits, an optional parity bit and the first stop bit, one per bit period, at each bit's centre. Each completed word goes into a receive buffer and raises a ready flag.

The word length (5 to 8 bits), parity enable and parity sense come in as static control fields, the same fields a paired transmitter uses. The receiver captures them when a frame starts. A host reads the buffer and drops the ready flag with an active-low clear strobe. Parity, framing and overrun problems are reported on sticky flags. Only the master reset clears these flags, and that reset leaves the buffer contents alone.

Top module: `serial_rx_core`

## Requirements
- R1: While and right after master reset, rx_ready, err_parity, err_frame and err_overrun are all 0.
- R2: A frame starts when a sample-enable pulse sees rx_line low and the previous pulse saw it high. The line is checked again on the 8th pulse after that one. If it is high then, the event is dropped, and the buffer and flags keep their values.
- R3: Data bits are taken LSB first, each on the 16th pulse after the previous sample point. len_code selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. A short word sits in the low bits of rx_word and the bits above it read 0.
- R4: With par_off=0, one parity bit follows the data bits. par_even=1 expects an even number of ones over the data and parity bits, and par_even=0 expects an odd number. On a mismatch err_parity sets. With par_off=1 no parity bit is received and err_parity does not set.
- R5: err_frame sets when the sample at the centre of the first stop bit is low.
- R6: When the stop bit has been sampled, rx_word takes the new word and rx_ready goes to 1, two clock cycles after that sample pulse. A cycle with rdy_clr_n=0 and no arriving word clears rx_ready.
- R7: err_overrun sets when a word is written into the buffer while rx_ready is still 1. The newer word replaces the older one.
- R8: Once err_parity, err_frame or err_overrun is set, it stays set until master reset.
- R9: Master reset clears rx_ready and the three error flags and abandons any frame in progress. rx_word keeps its value.
- R10: len_code, par_off and par_even are captured at frame start. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Master reset, asynchronous, active high |
| samp_en | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| len_code | input | LEN_W (2) | Data length select |
| par_off | input | 1 | 1 = no parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rdy_clr_n | input | 1 | Active-low clear of rx_ready |
| rx_word | output | MAX_W (8) | Receive buffer |
| rx_ready | output | 1 | New word present |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The bench builds the receiver with its defaults: an 8-bit buffer, a 5-bit minimum length and 16x oversampling. It raises samp_en every third clock, so one bit period is 48 clocks. With these values all four length codes, both parity senses and the no-parity mode occur within a few frames. They also fit in one run a start glitch shorter than half a bit, a control change in the middle of a frame, and back-to-back words that overrun the buffer.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP
   } srx_state_e;

   typedef struct packed {
      logic pbad;
      logic fbad;
   } srx_err_t;

endpackage

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic mreset,
   input  logic en,
   input  logic restart,
   input  logic run,
   output logic strobe
);
   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("srx_bit_timer: OVS must be even and at least 4");
      end
   endgenerate

   logic [CW-1:0] left;

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset) begin
         left <= '0;
      end else if (restart) begin
         left <= CW'(HALF - 1);
      end else if (run && en) begin
         if (left == '0) left <= CW'(OVS - 1);
         else            left <= left - 1'b1;
      end
   end

   assign strobe = run & en & (left == '0);

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
   import srx_pkg::*;
#(
   parameter int MAX_W = 8,
   parameter int MIN_W = 5,
   parameter int OVS   = 16,
   localparam int LEN_W = $clog2(MAX_W - MIN_W + 1)
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic             en,
   input  logic             line,
   input  logic [LEN_W-1:0] len_code,
   input  logic             par_off,
   input  logic             par_even,
   output logic             done,
   output logic [MAX_W-1:0] word_o,
   output srx_err_t         err_o
);
   localparam int IW = $clog2(MAX_W);
   localparam int NW = $clog2(MAX_W + 1);

   generate
      if ((1 << LEN_W) != (MAX_W - MIN_W + 1)) begin : g_bad_len
         $error("srx_frame_fsm: length range must span a power of two");
      end
   endgenerate

   srx_state_e       state;
   logic             line_q;
   logic [LEN_W-1:0] len_q;
   logic             poff_q;
   logic             peven_q;
   logic [IW-1:0]    bit_idx;
   logic             pbit;
   logic [MAX_W-1:0] cap;
   logic             fall;
   logic             strobe;
   logic [NW-1:0]    nbits;
   logic             last_bit;
   logic             ones_odd;

   assign fall     = en & line_q & ~line & (state == S_IDLE);
   assign nbits    = NW'(MIN_W) + NW'(len_q);
   assign last_bit = (NW'(bit_idx) == nbits - NW'(1));
   assign ones_odd = (^cap) ^ pbit;

   srx_bit_timer #(.OVS(OVS)) timer_i (
      .clk     (clk),
      .mreset  (mreset),
      .en      (en),
      .restart (fall),
      .run     (state != S_IDLE),
      .strobe  (strobe)
   );

   for (genvar i = 0; i < MAX_W; i++) begin : g_cap
      logic b;
      always_ff @(posedge clk or posedge mreset) begin
         if (mreset)
            b <= 1'b0;
         else if (fall)
            b <= 1'b0;
         else if (strobe && state == S_DATA && bit_idx == IW'(i))
            b <= line;
      end
      assign cap[i] = b;
   end

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset) begin
         state   <= S_IDLE;
         line_q  <= 1'b1;
         len_q   <= '0;
         poff_q  <= 1'b1;
         peven_q <= 1'b0;
         bit_idx <= '0;
         pbit    <= 1'b0;
         done    <= 1'b0;
         word_o  <= '0;
         err_o   <= '0;
      end else begin
         done <= 1'b0;
         if (en) line_q <= line;
         unique case (state)
            S_IDLE: begin
               if (fall) begin
                  state   <= S_START;
                  len_q   <= len_code;
                  poff_q  <= par_off;
                  peven_q <= par_even;
                  pbit    <= 1'b0;
               end
            end
            S_START: begin
               bit_idx <= '0;
               if (strobe) state <= line ? S_IDLE : S_DATA;
            end
            S_DATA: begin
               if (strobe) begin
                  if (last_bit) state <= poff_q ? S_STOP : S_PAR;
                  else          bit_idx <= bit_idx + 1'b1;
               end
            end
            S_PAR: begin
               if (strobe) begin
                  pbit  <= line;
                  state <= S_STOP;
               end
            end
            S_STOP: begin
               if (strobe) begin
                  done       <= 1'b1;
                  word_o     <= cap;
                  err_o.fbad <= ~line;
                  err_o.pbad <= ~poff_q & (peven_q ? ones_odd : ~ones_odd);
                  state      <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/srx_status.sv
module srx_status
   import srx_pkg::*;
#(
   parameter int MAX_W = 8
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic             done,
   input  logic [MAX_W-1:0] word_in,
   input  srx_err_t         err_in,
   input  logic             clr_n,
   output logic [MAX_W-1:0] buf_word,
   output logic             ready,
   output logic             pe,
   output logic             fe,
   output logic             oe
);

   always_ff @(posedge clk) begin
      if (done) buf_word <= word_in;
   end

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset) begin
         ready <= 1'b0;
         pe    <= 1'b0;
         fe    <= 1'b0;
         oe    <= 1'b0;
      end else begin
         if (done)        ready <= 1'b1;
         else if (!clr_n) ready <= 1'b0;
         if (done) begin
            oe <= oe | ready;
            pe <= pe | err_in.pbad;
            fe <= fe | err_in.fbad;
         end
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import srx_pkg::*;
#(
   parameter int MAX_W = 8,
   parameter int MIN_W = 5,
   parameter int OVS   = 16,
   localparam int LEN_W = $clog2(MAX_W - MIN_W + 1)
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic             samp_en,
   input  logic             rx_line,
   input  logic [LEN_W-1:0] len_code,
   input  logic             par_off,
   input  logic             par_even,
   input  logic             rdy_clr_n,
   output logic [MAX_W-1:0] rx_word,
   output logic             rx_ready,
   output logic             err_parity,
   output logic             err_frame,
   output logic             err_overrun
);

   generate
      if (MIN_W < 1 || MAX_W < MIN_W) begin : g_bad_w
         $error("serial_rx_core: bad width range");
      end
   endgenerate

   logic             done_w;
   logic [MAX_W-1:0] word_w;
   srx_err_t         err_w;

   srx_frame_fsm #(.MAX_W(MAX_W), .MIN_W(MIN_W), .OVS(OVS)) fsm_i (
      .clk      (clk),
      .mreset   (mreset),
      .en       (samp_en),
      .line     (rx_line),
      .len_code (len_code),
      .par_off  (par_off),
      .par_even (par_even),
      .done     (done_w),
      .word_o   (word_w),
      .err_o    (err_w)
   );

   srx_status #(.MAX_W(MAX_W)) status_i (
      .clk      (clk),
      .mreset   (mreset),
      .done     (done_w),
      .word_in  (word_w),
      .err_in   (err_w),
      .clr_n    (rdy_clr_n),
      .buf_word (rx_word),
      .ready    (rx_ready),
      .pe       (err_parity),
      .fe       (err_frame),
      .oe       (err_overrun)
   );

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
   input logic clk,
   input logic mreset,
   input logic rdy_clr_n,
   input logic rx_ready,
   input logic err_parity,
   input logic err_frame,
   input logic err_overrun,
   input logic done,
   input logic pbad,
   input logic fbad
);

   always @(posedge clk) begin
      if (mreset) begin
         p_reset_clear_r9: assert (!rx_ready && !err_parity && !err_frame && !err_overrun)
            else $error("R9: flags not clear under master reset");
      end
   end

   p_ready_rise_r6: assert property (@(posedge clk) disable iff (mreset)
      $rose(rx_ready) |-> $past(done));

   p_ready_fall_r6: assert property (@(posedge clk) disable iff (mreset)
      $fell(rx_ready) |-> $past(!rdy_clr_n));

   p_ovr_rise_r7: assert property (@(posedge clk) disable iff (mreset)
      $rose(err_overrun) |-> $past(done && rx_ready));

   p_frame_rise_r5: assert property (@(posedge clk) disable iff (mreset)
      $rose(err_frame) |-> $past(done && fbad));

   p_par_rise_r4: assert property (@(posedge clk) disable iff (mreset)
      $rose(err_parity) |-> $past(done && pbad));

   p_par_sticky_r8: assert property (@(posedge clk) disable iff (mreset)
      err_parity |=> err_parity);

   p_frame_sticky_r8: assert property (@(posedge clk) disable iff (mreset)
      err_frame |=> err_frame);

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (mreset)
      err_overrun |=> err_overrun);

endmodule

bind serial_rx_core srx_checker chk_i (
   .clk         (clk),
   .mreset      (mreset),
   .rdy_clr_n   (rdy_clr_n),
   .rx_ready    (rx_ready),
   .err_parity  (err_parity),
   .err_frame   (err_frame),
   .err_overrun (err_overrun),
   .done        (done_w),
   .pbad        (err_w.pbad),
   .fbad        (err_w.fbad)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;

   localparam int EN_DIV = 3;

   logic       clk = 1'b0;
   logic       mreset = 1'b1;
   logic       samp_en = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] len_code = 2'd3;
   logic       par_off = 1'b1;
   logic       par_even = 1'b0;
   logic       rdy_clr_n = 1'b1;
   logic [7:0] rx_word;
   logic       rx_ready, err_parity, err_frame, err_overrun;

   int n_chk = 0;
   int n_bad = 0;
   int div = 0;

   always #10 clk = ~clk;

   serial_rx_core dut_i (
      .clk(clk), .mreset(mreset), .samp_en(samp_en), .rx_line(rx_line),
      .len_code(len_code), .par_off(par_off), .par_even(par_even),
      .rdy_clr_n(rdy_clr_n), .rx_word(rx_word), .rx_ready(rx_ready),
      .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
   );

   always @(negedge clk) begin
      div     = (div == EN_DIV - 1) ? 0 : div + 1;
      samp_en <= (div == 0);
   end

   // reference model: counts enable pulses since the detected falling edge
   bit       m_busy = 0, m_prev = 1, m_poff = 1, m_even = 0, m_pbit = 0;
   int       m_k = 0, m_nb = 8;
   bit [7:0] m_word = 0;
   bit       pend = 0, pend_pb = 0, pend_fb = 0;
   bit [7:0] pend_w = 0;
   bit       e_ready = 0, e_pe = 0, e_fe = 0, e_oe = 0, m_have = 0;
   bit [7:0] e_word = 0;

   always @(posedge clk or posedge mreset) begin
      if (mreset) begin
         m_busy = 0; m_prev = 1; pend = 0;
         e_ready = 0; e_pe = 0; e_fe = 0; e_oe = 0;
      end else begin
         if (pend) begin
            e_oe = e_oe | e_ready;
            e_ready = 1; e_word = pend_w; m_have = 1;
            e_pe = e_pe | pend_pb; e_fe = e_fe | pend_fb;
            pend = 0;
         end else if (!rdy_clr_n) begin
            e_ready = 0;
         end
         if (samp_en) begin
            if (!m_busy) begin
               if (m_prev && !rx_line) begin
                  m_busy = 1; m_k = 0; m_nb = 5 + int'(len_code);
                  m_poff = par_off; m_even = par_even; m_word = 0; m_pbit = 0;
               end
            end else begin
               m_k++;
               if (m_k == 8) begin
                  if (rx_line) m_busy = 0;
               end else if (m_k > 8 && (m_k - 8) % 16 == 0) begin
                  automatic int idx = (m_k - 8) / 16 - 1;
                  if (idx < m_nb) m_word[idx] = rx_line;
                  else if (!m_poff && idx == m_nb) m_pbit = rx_line;
                  else begin
                     automatic bit ones = (^m_word) ^ m_pbit;
                     pend = 1; pend_w = m_word; pend_fb = !rx_line;
                     pend_pb = !m_poff && (m_even ? ones : !ones);
                     m_busy = 0;
                  end
               end
            end
            m_prev = rx_line;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   bit run_cmp = 0;
   always @(negedge clk) begin
      if (run_cmp && !mreset) begin
         chk(rx_ready == e_ready, "R6 ready vs model", 32'(rx_ready), 32'(e_ready));
         chk(err_parity == e_pe, "R4 parity flag vs model", 32'(err_parity), 32'(e_pe));
         chk(err_frame == e_fe, "R5 frame flag vs model", 32'(err_frame), 32'(e_fe));
         chk(err_overrun == e_oe, "R7 overrun flag vs model", 32'(err_overrun), 32'(e_oe));
         if (m_have) chk(rx_word == e_word, "R3 word vs model", 32'(rx_word), 32'(e_word));
      end
   end

   task automatic wait_en(input int n);
      int c = 0;
      while (c < n) begin
         @(posedge clk);
         if (samp_en) c++;
      end
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                             input bit even, input bit flip, input bit stop_v);
      bit p = 0;
      rx_line = 0; wait_en(16);
      for (int i = 0; i < nb; i++) begin
         rx_line = d[i]; p = p ^ d[i]; wait_en(16);
      end
      if (pen) begin
         rx_line = (even ? p : !p) ^ flip; wait_en(16);
      end
      rx_line = stop_v; wait_en(16);
      rx_line = 1; wait_en(4);
   endtask

   task automatic clear_ready();
      rdy_clr_n = 0; @(negedge clk); rdy_clr_n = 1; @(negedge clk);
   endtask

   task automatic pulse_reset();
      mreset = 1; repeat (2) @(negedge clk); mreset = 0; @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      mreset = 0;
      @(negedge clk);
      run_cmp = 1;
      // R1
      chk(!rx_ready && !err_parity && !err_frame && !err_overrun, "R1 reset state",
          {28'd0, rx_ready, err_parity, err_frame, err_overrun}, 0);
      wait_en(20);

      // 8 bits, even parity (R3, R4, R6)
      len_code = 3; par_off = 0; par_even = 1;
      send_frame(8'hA5, 8, 1, 1, 0, 1);
      chk(rx_ready == 1, "R6 ready after word", 32'(rx_ready), 1);
      chk(rx_word == 8'hA5, "R3 8-bit word", 32'(rx_word), 32'hA5);
      chk(err_parity == 0, "R4 good even parity", 32'(err_parity), 0);
      clear_ready();
      chk(rx_ready == 0, "R6 clear strobe", 32'(rx_ready), 0);

      // 5 bits, no parity (R3)
      len_code = 0; par_off = 1;
      send_frame(8'h15, 5, 0, 0, 0, 1);
      chk(rx_word == 8'h15, "R3 5-bit right justified", 32'(rx_word), 32'h15);
      clear_ready();

      // 6 bits, odd parity; upper data bits on the stimulus must not appear
      len_code = 1; par_off = 0; par_even = 0;
      send_frame(8'hEA, 6, 1, 0, 0, 1);
      chk(rx_word == 8'h2A, "R3 6-bit zero fill", 32'(rx_word), 32'h2A);
      chk(err_parity == 0, "R4 good odd parity", 32'(err_parity), 0);
      clear_ready();

      // 7 bits, even parity
      len_code = 2; par_even = 1;
      send_frame(8'h5B, 7, 1, 1, 0, 1);
      chk(rx_word == 8'h5B, "R3 7-bit word", 32'(rx_word), 32'h5B);
      clear_ready();

      // start glitch (R2)
      rx_line = 0; wait_en(3); rx_line = 1; wait_en(40);
      chk(rx_ready == 0, "R2 glitch gives no word", 32'(rx_ready), 0);
      chk(rx_word == 8'h5B, "R2 buffer kept after glitch", 32'(rx_word), 32'h5B);

      // overrun (R7)
      len_code = 3; par_off = 1;
      send_frame(8'h11, 8, 0, 0, 0, 1);
      send_frame(8'h22, 8, 0, 0, 0, 1);
      chk(err_overrun == 1, "R7 overrun set", 32'(err_overrun), 1);
      chk(rx_word == 8'h22, "R7 newer word kept", 32'(rx_word), 32'h22);

      // master reset (R9)
      pulse_reset();
      chk(!rx_ready && !err_overrun, "R9 reset clears flags", {30'd0, rx_ready, err_overrun}, 0);
      chk(rx_word == 8'h22, "R9 buffer kept across reset", 32'(rx_word), 32'h22);

      // control change mid-frame (R10)
      len_code = 3; par_off = 1;
      fork
         send_frame(8'hC3, 8, 0, 0, 0, 1);
         begin wait_en(40); len_code = 0; par_off = 0; end
      join
      chk(rx_word == 8'hC3, "R10 latched length", 32'(rx_word), 32'hC3);
      chk(err_parity == 0 && err_frame == 0, "R10 latched parity mode",
          {30'd0, err_parity, err_frame}, 0);
      clear_ready();

      // parity error and stickiness (R4, R8)
      len_code = 3; par_off = 0; par_even = 1;
      send_frame(8'h3C, 8, 1, 1, 1, 1);
      chk(err_parity == 1, "R4 parity mismatch", 32'(err_parity), 1);
      clear_ready();
      send_frame(8'h3D, 8, 1, 1, 0, 1);
      chk(err_parity == 1, "R8 parity flag sticky", 32'(err_parity), 1);
      pulse_reset();

      // framing error and stickiness (R5, R8)
      par_off = 1;
      send_frame(8'h81, 8, 0, 0, 0, 0);
      chk(err_frame == 1, "R5 low stop bit", 32'(err_frame), 1);
      wait_en(20);
      clear_ready();
      send_frame(8'h42, 8, 0, 0, 0, 1);
      chk(err_frame == 1, "R8 frame flag sticky", 32'(err_frame), 1);
      pulse_reset();

      // parity disabled: odd-looking data never flags (R4)
      len_code = 3; par_off = 1; par_even = 1;
      send_frame(8'h01, 8, 0, 0, 0, 1);
      chk(err_parity == 0, "R4 parity off no flag", 32'(err_parity), 0);
      chk(rx_word == 8'h01, "R3 word with parity off", 32'(rx_word), 32'h01);

      run_cmp = 0;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule